// File: doc/BRIEF.md
# ISA Interrupt Mask Controller

This block sits on an 8-bit ISA I/O bus and collects eighteen level-sensitive interrupt request lines from the PCI side. Sixteen of them come from four groups (A, B, C, D), each with four lines. The other two are a disk-controller line (IDE) and a super-I/O line (SIO). It merges them into one interrupt output for the host.

The block holds three write-only mask bytes at three consecutive I/O addresses. Software writes them to turn each source on or off. A read at any of the three addresses returns the live, unmasked request levels, never the mask. The bus strobes are sampled on the block clock. A mask byte takes effect at the end of its write strobe. The combined output is registered once.

Top module: `isa_irq_mask_ctl`

## Requirements
- R1: The block decodes an access only when `hi_sel` equals parameter `HI_MATCH` (default 3'b101) and `sa` is 4, 5 or 6. Those addresses select byte 0, byte 1 and byte 2. Every other address is ignored.
- R2: The request image is laid out as follows, with group line n written Gn.
  - Byte 0: bit 0 = A0, bit 1 = A1, bit 2 = A2, bit 3 = A3, bit 4 reserved, bit 5 = SIO, bit 6 = IDE, bit 7 = B0.
  - Byte 1: bit 0 = B1, bit 1 = B2, bit 2 = B3, bits 3..6 = C0..C3, bit 7 = D0.
  - Byte 2: bits 0..2 = D1..D3, bits 3..7 reserved.
  - `req_grp` bits 0..3 carry A0..A3, bits 4..7 carry B0..B3, bits 8..11 carry C0..C3 and bits 12..15 carry D0..D3.
- R3: A decoded read returns the raw request levels in the R2 layout, whatever the masks hold. A 1 means the source is asserting. Reserved bits read 0.
- R4: `data_oe` is 1 exactly while `ior_n` is low at a decoded address. At all other times `data_oe` is 0 and `data_o` is 0.
- R5: A mask bit of 1 disables its source and a mask bit of 0 enables it. `irq_o` is registered and equals, one clock later, the OR of all requests whose mask bit is 0.
- R6: While reset is asserted, `irq_o` is 0. After reset every mask bit is 1, so no request reaches `irq_o` until software writes a mask.
- R7: A mask write uses the address and data sampled on the last clock at which `iow_n` was low. It commits on the first clock at which `iow_n` is seen high again. Bus changes at the release are ignored. `irq_o` reflects the new mask one clock after the commit.
- R8: Writes to non-decoded addresses leave all masks unchanged. Values written to reserved bit positions have no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa | input | 3 | Low ISA address bits |
| hi_sel | input | 3 | Extra high-order address decode bits |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| data_i | input | 8 | Write data from the bus |
| data_o | output | 8 | Read data to the bus |
| data_oe | output | 1 | Tristate enable for data_o |
| req_grp | input | 16 | Group A..D request lines, four per group |
| req_ide | input | 1 | Disk-controller request |
| req_sio | input | 1 | Super-I/O request |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The bench walks every one of the eighteen sources with only that source enabled. A wrong bit position therefore shows up either as a silent output or as an interrupt from a neighbouring line. It reads every byte under many request patterns, and reads again after masks are loaded. A design that returned the mask, or leaked a reserved bit, would fail those reads. It writes to every undecoded address and to reserved positions, which exposes a decoder that is too loose or a reserved mask bit that gates a real source. Write timing is checked by scrambling the bus at strobe release and by changing the data during a long strobe. A design that commits early or latches the release value would load the wrong byte.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 3;
  localparam int IMG_W     = BYTE_W * NUM_BYTES;
  localparam int IDX_W     = $clog2(NUM_BYTES);
  localparam int GRP_W     = 16;

  // positions carrying a real source (byte0 bit4 and byte2 bits 7:3 reserved)
  localparam logic [IMG_W-1:0] IMPL_BITS = 24'h07_FF_EF;

  function automatic logic [IMG_W-1:0] pack_requests(input logic [GRP_W-1:0] grp,
                                                     input logic ide,
                                                     input logic sio);
    logic [IMG_W-1:0] img;
    img        = '0;
    img[3:0]   = grp[3:0];
    img[5]     = sio;
    img[6]     = ide;
    img[7]     = grp[4];
    img[10:8]  = grp[7:5];
    img[14:11] = grp[11:8];
    img[15]    = grp[12];
    img[18:16] = grp[15:13];
    return img;
  endfunction
endpackage

// File: rtl/isa_irq_decode.sv
module isa_irq_decode
  import isa_irq_pkg::*;
#(
  parameter logic [2:0] HI_MATCH = 3'b101,
  parameter logic [2:0] LOW_BASE = 3'd4
) (
  input  logic [2:0]       sa,
  input  logic [2:0]       hi_sel,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [2:0] SPAN = 3'(NUM_BYTES);

  logic [2:0] offset;

  always_comb begin
    offset = sa - LOW_BASE;
    hit    = (hi_sel == HI_MATCH) && (sa >= LOW_BASE) && (offset < SPAN);
    idx    = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/isa_irq_wrcap.sv
module isa_irq_wrcap
  import isa_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iow_n,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] data_i,
  output logic [IMG_W-1:0]  mask_o
);
  logic              iow_q, iow_d;
  logic              hold_hit_q, hold_hit_d;
  logic [IDX_W-1:0]  hold_idx_q, hold_idx_d;
  logic [BYTE_W-1:0] hold_dat_q, hold_dat_d;
  logic              strobe_lo;
  logic              commit;

  always_comb begin
    strobe_lo  = ~iow_n;
    commit     = ~iow_q & iow_n & hold_hit_q;
    iow_d      = iow_n;
    hold_hit_d = strobe_lo ? hit    : hold_hit_q;
    hold_idx_d = strobe_lo ? idx    : hold_idx_q;
    hold_dat_d = strobe_lo ? data_i : hold_dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iow_q      <= 1'b1;
      hold_hit_q <= 1'b0;
      hold_idx_q <= '0;
      hold_dat_q <= '0;
    end else begin
      iow_q      <= iow_d;
      hold_hit_q <= hold_hit_d;
      hold_idx_q <= hold_idx_d;
      hold_dat_q <= hold_dat_d;
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_mask
    localparam logic [BYTE_W-1:0] IMPL_B = IMPL_BITS[b*BYTE_W +: BYTE_W];
    logic [BYTE_W-1:0] mask_q, mask_d;
    logic              load_en;

    always_comb begin
      load_en = commit && (hold_idx_q == IDX_W'(b));
      // reserved positions are pinned disabled
      mask_d  = load_en ? ((hold_dat_q & IMPL_B) | ~IMPL_B) : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '1;
      else        mask_q <= mask_d;
    end

    assign mask_o[b*BYTE_W +: BYTE_W] = mask_q;
  end
endmodule

// File: rtl/isa_irq_rdmux.sv
module isa_irq_rdmux
  import isa_irq_pkg::*;
(
  input  logic [IMG_W-1:0]  img,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic              ior_n,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe
);
  logic [BYTE_W-1:0] bytes [NUM_BYTES];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign bytes[b] = img[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    data_oe = hit & ~ior_n;
    data_o  = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (data_oe && idx == IDX_W'(b)) data_o = bytes[b];
    end
  end
endmodule

// File: rtl/isa_irq_mask_ctl.sv
module isa_irq_mask_ctl
  import isa_irq_pkg::*;
#(
  parameter logic [2:0] HI_MATCH = 3'b101,
  parameter logic [2:0] LOW_BASE = 3'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sa,
  input  logic [2:0]        hi_sel,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe,
  input  logic [GRP_W-1:0]  req_grp,
  input  logic              req_ide,
  input  logic              req_sio,
  output logic              irq_o
);
  logic [1:0]       rsync_q, rsync_d;
  logic             rst_int_n;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [IMG_W-1:0] img;
  logic [IMG_W-1:0] mask;
  logic             irq_q, irq_d;

  // reset asserts at once and releases two clocks later
  always_comb rsync_d = {rsync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= rsync_d;
  end

  assign rst_int_n = rsync_q[1];

  isa_irq_decode #(.HI_MATCH(HI_MATCH), .LOW_BASE(LOW_BASE)) dec_i (
    .sa(sa), .hi_sel(hi_sel), .hit(hit), .idx(idx)
  );

  assign img = pack_requests(req_grp, req_ide, req_sio);

  isa_irq_wrcap wr_i (
    .clk(clk), .rst_n(rst_int_n), .iow_n(iow_n), .hit(hit), .idx(idx),
    .data_i(data_i), .mask_o(mask)
  );

  isa_irq_rdmux rd_i (
    .img(img), .hit(hit), .idx(idx), .ior_n(ior_n),
    .data_o(data_o), .data_oe(data_oe)
  );

  always_comb irq_d = |(img & ~mask & IMPL_BITS);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/isa_irq_mask_chk.sv
module isa_irq_mask_chk #(
  parameter logic [2:0] HI_MATCH = 3'b101,
  parameter logic [2:0] LOW_BASE = 3'd4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  sa,
  input logic [2:0]  hi_sel,
  input logic        ior_n,
  input logic [7:0]  data_o,
  input logic        data_oe,
  input logic [15:0] req_grp,
  input logic        req_ide,
  input logic        req_sio,
  input logic        irq_o
);
  localparam logic [2:0] SA1 = LOW_BASE + 3'd1;
  localparam logic [2:0] SA2 = LOW_BASE + 3'd2;

  logic dec_ok;
  logic req_none;
  assign dec_ok   = (hi_sel == HI_MATCH) && (sa == LOW_BASE || sa == SA1 || sa == SA2);
  assign req_none = (req_grp == 16'h0) && !req_ide && !req_sio;

  // R4
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ior_n && dec_ok));
  // R4
  rd_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n && dec_ok) |-> data_oe);
  // R3
  byte0_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && sa == LOW_BASE) |->
      data_o == {req_grp[4], req_ide, req_sio, 1'b0, req_grp[3:0]});
  // R3
  byte1_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && sa == SA1) |-> data_o == req_grp[12:5]);
  // R3
  byte2_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && sa == SA2) |-> data_o == {5'b0, req_grp[15:13]});
  // R5
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_none |=> !irq_o);
  // R6
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |-> !irq_o);
endmodule

bind isa_irq_mask_ctl isa_irq_mask_chk #(.HI_MATCH(HI_MATCH), .LOW_BASE(LOW_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .sa(sa), .hi_sel(hi_sel), .ior_n(ior_n),
  .data_o(data_o), .data_oe(data_oe), .req_grp(req_grp), .req_ide(req_ide),
  .req_sio(req_sio), .irq_o(irq_o)
);

// File: tb/isa_irq_mask_ctl_tb.sv
`timescale 1ns/1ps
module isa_irq_mask_ctl_tb_top;
  localparam logic [2:0] HI = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sa, hi_sel;
  logic        ior_n, iow_n;
  logic [7:0]  data_i, data_o;
  logic        data_oe;
  logic [15:0] req_grp;
  logic        req_ide, req_sio;
  logic        irq_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  isa_irq_mask_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .sa(sa), .hi_sel(hi_sel), .ior_n(ior_n),
    .iow_n(iow_n), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
    .req_grp(req_grp), .req_ide(req_ide), .req_sio(req_sio), .irq_o(irq_o)
  );

  // source s: 0..15 group lines, 16 IDE, 17 SIO -> image bit position
  function automatic int pos_of(int s);
    if (s < 4)  return s;
    if (s == 4) return 7;
    if (s < 16) return s + 3;
    if (s == 16) return 6;
    return 5;
  endfunction

  function automatic logic [23:0] to_img(logic [17:0] v, logic fill);
    logic [23:0] r;
    r = fill ? 24'hFFFFFF : 24'h0;
    for (int s = 0; s < 18; s++) r[pos_of(s)] = v[s];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_req(logic [17:0] v);
    req_grp = v[15:0];
    req_ide = v[16];
    req_sio = v[17];
  endtask

  task automatic wr(logic [2:0] a, logic [2:0] h, logic [7:0] d);
    @(negedge clk);
    sa = a; hi_sel = h; data_i = d; iow_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    iow_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_mask(logic [17:0] m);
    logic [23:0] img;
    img = to_img(m, 1'b1);
    wr(3'd4, HI, img[7:0]);
    wr(3'd5, HI, img[15:8]);
    wr(3'd6, HI, img[23:16]);
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [2:0] h, logic oe, logic [7:0] d);
    @(negedge clk);
    sa = a; hi_sel = h; ior_n = 1'b0;
    #1;
    chk(tag, {31'b0, data_oe}, {31'b0, oe});
    chk(tag, {24'b0, data_o}, {24'b0, d});
    ior_n = 1'b1;
  endtask

  task automatic rd_all(string tag, logic [17:0] v);
    logic [23:0] e;
    e = to_img(v, 1'b0);
    for (int k = 0; k < 3; k++) rd(tag, 3'(4 + k), HI, 1'b1, e[k*8 +: 8]);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] lfsr;
    rst_n = 1'b0; sa = 3'd0; hi_sel = 3'd0; ior_n = 1'b1; iow_n = 1'b1;
    data_i = 8'h0; set_req(18'h0);
    repeat (3) @(negedge clk);
    chk("R6 irq in reset", {31'b0, irq_o}, 0);
    chk("R4 oe idle", {31'b0, data_oe}, 0);
    set_req(18'h3FFFF);
    repeat (2) @(negedge clk);
    chk("R6 irq in reset reqs high", {31'b0, irq_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 all masked after reset", {31'b0, irq_o}, 0);

    // R3 R2 raw read sweep
    lfsr = 18'h2A5C1;
    for (int n = 0; n < 40; n++) begin
      set_req(lfsr);
      rd_all("R3 raw read", lfsr);
      lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
    end
    for (int s = 0; s < 18; s++) begin
      set_req(18'(1) << s);
      rd_all("R2 single source read", 18'(1) << s);
    end

    // R1 R4 undecoded reads
    set_req(18'h3FFFF);
    for (int a = 0; a < 8; a++) begin
      if (a < 4 || a > 6) rd("R1 undecoded sa", 3'(a), HI, 1'b0, 8'h0);
    end
    for (int h = 0; h < 8; h++) begin
      if (3'(h) != HI) rd("R1 wrong hi_sel", 3'd5, 3'(h), 1'b0, 8'h0);
    end
    @(negedge clk);
    sa = 3'd4; hi_sel = HI; ior_n = 1'b1;
    #1;
    chk("R4 no strobe no drive", {31'b0, data_oe}, 0);
    chk("R4 no strobe data zero", {24'b0, data_o}, 0);

    // R5 R2 per-source enable sweep
    for (int s = 0; s < 18; s++) begin
      logic [17:0] m;
      m = ~(18'(1) << s);
      wr_mask(m);
      set_req(~(18'(1) << s));
      @(negedge clk);
      chk("R5 other sources masked", {31'b0, irq_o}, 0);
      set_req(18'(1) << s);
      @(negedge clk);
      chk("R5 enabled source fires", {31'b0, irq_o}, 1);
      rd_all("R3 read ignores mask", 18'(1) << s);
      set_req(18'h0);
      @(negedge clk);
      chk("R5 deassert follows", {31'b0, irq_o}, 0);
    end

    // R8 ignored writes
    wr_mask(18'h3FFFF);
    set_req(18'h3FFFF);
    @(negedge clk);
    chk("R8 masked baseline", {31'b0, irq_o}, 0);
    wr(3'd7, HI, 8'h00);
    chk("R8 write sa7 ignored", {31'b0, irq_o}, 0);
    wr(3'd3, HI, 8'h00);
    chk("R8 write sa3 ignored", {31'b0, irq_o}, 0);
    wr(3'd4, HI ^ 3'b001, 8'h00);
    chk("R8 write wrong hi ignored", {31'b0, irq_o}, 0);
    wr(3'd5, ~HI, 8'h00);
    chk("R8 write inverted hi ignored", {31'b0, irq_o}, 0);
    wr(3'd4, HI, 8'hEF);
    chk("R8 reserved bit4 no effect", {31'b0, irq_o}, 0);
    wr(3'd6, HI, 8'h07);
    chk("R8 reserved byte2 no effect", {31'b0, irq_o}, 0);
    wr(3'd6, HI, 8'hF8);
    chk("R5 byte2 enable D1-D3", {31'b0, irq_o}, 1);
    wr(3'd6, HI, 8'hFF);
    chk("R5 byte2 disable again", {31'b0, irq_o}, 0);

    // R7 commit timing, release scrambles bus
    @(negedge clk);
    sa = 3'd5; hi_sel = HI; data_i = 8'h00; iow_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 no commit while strobe low", {31'b0, irq_o}, 0);
    iow_n = 1'b1; sa = 3'd7; hi_sel = 3'd0; data_i = 8'hFF;
    @(negedge clk);
    chk("R7 irq one clock after commit", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R7 held values committed", {31'b0, irq_o}, 1);
    repeat (3) @(negedge clk);
    chk("R7 mask persists", {31'b0, irq_o}, 1);

    // R7 last low sample wins
    @(negedge clk);
    sa = 3'd5; hi_sel = HI; data_i = 8'h00; iow_n = 1'b0;
    @(negedge clk);
    data_i = 8'hFF;
    @(negedge clk);
    iow_n = 1'b1; data_i = 8'h00;
    repeat (2) @(negedge clk);
    chk("R7 last sampled data wins", {31'b0, irq_o}, 0);

    // R6 reset mid-run restores masks
    wr(3'd4, HI, 8'h00);
    chk("R5 byte0 enabled", {31'b0, irq_o}, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6 async clear", {31'b0, irq_o}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 masks restored", {31'b0, irq_o}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule